// File: doc/BRIEF.md
# Multiplexed Address/Data Bus Sequencer

This block runs the external bus of a 16-bit embedded processor core. Every read or write the core issues becomes a four-phase bus cycle (t1, t2, t3, t4). A 20-bit address output holds the address for the whole cycle. A 16-bit shared address/data output normally carries the low address bits in t1 and data in the later phases. A chip-select line for the addressed region stays asserted from t1 to t4.

To save switching power, the shared bus can be left floating in t1 for accesses to the upper or the lower memory region. Each of those two regions has its own bit in a small configuration register. A strap input is captured once as reset is released. If it is low, both bits are ignored and every cycle puts the address on the shared bus, as a classic multiplexed bus does. The core sees a ready signal that allows a new request while the block is idle or in t4, and a one-cycle done pulse in t4 that carries read data.

Top module: `mux_bus_seq`

## Requirements
- R1: After reset the block is idle: `req_ready`=1, `done`=0, `pad_cs`=0, `pad_ad_oe`=0, and both configuration bits are 0.
- R2: A request accepted on a clock edge gives phases t1, t2, t3 and t4 in the four following cycles. `done` is high in t4 only and is never high for two cycles in a row. Without a follow-on request the block is idle, with `pad_cs`=0, in the cycle after t4.
- R3: `pad_addr` equals the accepted request address in every phase from t1 to t4.
- R4: In t1 of a cycle whose address phase is not disabled, `pad_ad_oe`=1 and `pad_ad_out` equals the low 16 bits of the address.
- R5: For a write (`req_write`=1), `pad_ad_oe`=1 and `pad_ad_out` equals the write data in t2, t3 and t4.
- R6: For a read, `pad_ad_oe`=0 in t2, t3 and t4. `rdata` in the t4 cycle equals the value on `pad_ad_in` at the clock edge that ends t3.
- R7: The address phase is disabled (`pad_ad_oe`=0 in t1) when the region code is 1 (lower) and `cfg_wdata` bit 0 was last written as 1. It is also disabled when the region code is 2 (upper) and bit 1 was last written as 1. A configuration write takes effect for requests accepted after the write edge.
- R8: Region code 0 (other chip selects) and region code 3 (no chip select) never disable the address phase, whatever the configuration bits.
- R9: If `force_mux_n` is 0 when reset is released, no cycle disables the address phase until the next reset.
- R10: `force_mux_n` is captured only on the first clock edge after reset is released. Later changes to it have no effect.
- R11: `req_ready` is 0 in t1, t2 and t3 and is 1 in idle and t4. A request presented in t4 starts its t1 in the next cycle, with no idle cycle in between.
- R12: `pad_cs` is one-hot during t1 to t4. Bit n is set for region code n (0, 1, 2). Region code 3 asserts no bit. All bits are 0 when idle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| force_mux_n | input | 1 | Strap; 0 at reset release forces the address onto the shared bus in t1 |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_wdata | input | 2 | Bit 0: lower-region address disable; bit 1: upper-region address disable |
| req_valid | input | 1 | Core request present |
| req_ready | output | 1 | Block can accept a request this cycle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_region | input | 2 | Region hit: 0 other, 1 lower, 2 upper, 3 none |
| req_addr | input | 20 | Request address |
| req_wdata | input | 16 | Write data |
| done | output | 1 | One-cycle pulse in t4 |
| rdata | output | 16 | Read data, valid with `done` on a read |
| pad_addr | output | 20 | Non-multiplexed address output |
| pad_ad_out | output | 16 | Shared address/data output value |
| pad_ad_oe | output | 1 | Output enable of the shared bus |
| pad_ad_in | input | 16 | Shared bus input value |
| pad_cs | output | 3 | Region chip selects, active high |

## Verification
The assertions assume that region codes come from the four defined values. They also assume the configuration register is written only while no bus cycle is running, so the disable decision taken at acceptance agrees with the register read by the bench. The stimulus therefore writes the configuration only after it has returned the block to idle. It draws region, direction, address, data and chaining from a seeded generator, and it keeps `pad_ad_in` steady from t3 until after the edge that ends t3. Directed cases reset the block with the strap low and then with it high, toggle the strap after release, and chain cycles at t4.

// File: rtl/mbs_pkg.sv
package mbs_pkg;
   typedef enum logic [2:0] {
      PH_IDLE = 3'd0,
      PH_T1   = 3'd1,
      PH_T2   = 3'd2,
      PH_T3   = 3'd3,
      PH_T4   = 3'd4
   } phase_e;

   localparam int CFG_BITS = 2;
   localparam int CFG_LOWER_BIT = 0;
   localparam int CFG_UPPER_BIT = 1;
endpackage

// File: rtl/mbs_strap_cfg.sv
module mbs_strap_cfg #(
   parameter int CFG_W = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             strap_i,
   input  logic             cfg_we,
   input  logic [CFG_W-1:0] cfg_wdata,
   output logic             armed,
   output logic             strap_q,
   output logic             strap_eff,
   output logic [CFG_W-1:0] cfg_q
);
   // strap: captured once on the first edge after reset release
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         armed   <= 1'b1;
         strap_q <= 1'b0;
      end else if (armed) begin
         armed   <= 1'b0;
         strap_q <= strap_i;
      end
   end

   // while still armed, use the live pin so an early request sees the captured value
   assign strap_eff = armed ? strap_i : strap_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cfg_q <= '0;
      end else if (cfg_we) begin
         cfg_q <= cfg_wdata;
      end
   end
endmodule

// File: rtl/mbs_phase_fsm.sv
module mbs_phase_fsm
   import mbs_pkg::*;
#(
   parameter int ADDR_W = 20,
   parameter int DATA_W = 16,
   parameter int RG_W   = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              req_valid,
   input  logic              req_write,
   input  logic [RG_W-1:0]   req_region,
   input  logic [ADDR_W-1:0] req_addr,
   input  logic [DATA_W-1:0] req_wdata,
   input  logic              dis_now,
   output logic              req_ready,
   output phase_e            phase,
   output logic [ADDR_W-1:0] addr_q,
   output logic [DATA_W-1:0] wdata_q,
   output logic [RG_W-1:0]   region_q,
   output logic              wr_q,
   output logic              dis_q
);
   phase_e phase_nxt;
   logic   accept;

   assign req_ready = (phase == PH_IDLE) || (phase == PH_T4);
   assign accept    = req_valid && req_ready;

   always_comb begin
      phase_nxt = phase;
      unique case (phase)
         PH_IDLE: phase_nxt = accept ? PH_T1 : PH_IDLE;
         PH_T1:   phase_nxt = PH_T2;
         PH_T2:   phase_nxt = PH_T3;
         PH_T3:   phase_nxt = PH_T4;
         PH_T4:   phase_nxt = accept ? PH_T1 : PH_IDLE;
         default: phase_nxt = PH_IDLE;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         phase <= PH_IDLE;
      end else begin
         phase <= phase_nxt;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         addr_q   <= '0;
         wdata_q  <= '0;
         region_q <= '1;
         wr_q     <= 1'b0;
         dis_q    <= 1'b0;
      end else if (accept) begin
         addr_q   <= req_addr;
         wdata_q  <= req_wdata;
         region_q <= req_region;
         wr_q     <= req_write;
         dis_q    <= dis_now;
      end
   end
endmodule

// File: rtl/mbs_pad_drive.sv
module mbs_pad_drive
   import mbs_pkg::*;
#(
   parameter int ADDR_W = 20,
   parameter int DATA_W = 16,
   parameter int NUM_CS = 3,
   parameter int RG_W   = 2
) (
   input  phase_e            phase,
   input  logic [ADDR_W-1:0] addr_q,
   input  logic [DATA_W-1:0] wdata_q,
   input  logic [RG_W-1:0]   region_q,
   input  logic              wr_q,
   input  logic              dis_q,
   output logic [ADDR_W-1:0] pad_addr,
   output logic [DATA_W-1:0] pad_ad_out,
   output logic              pad_ad_oe,
   output logic [NUM_CS-1:0] pad_cs,
   output logic              done
);
   logic active;
   logic in_t1;

   assign active = (phase != PH_IDLE);
   assign in_t1  = (phase == PH_T1);
   assign done   = (phase == PH_T4);

   assign pad_addr = active ? addr_q : '0;

   always_comb begin
      pad_ad_oe  = 1'b0;
      pad_ad_out = '0;
      if (in_t1) begin
         pad_ad_oe  = !dis_q;
         pad_ad_out = dis_q ? '0 : addr_q[DATA_W-1:0];
      end else if (active && wr_q) begin
         pad_ad_oe  = 1'b1;
         pad_ad_out = wdata_q;
      end
   end

   for (genvar g = 0; g < NUM_CS; g++) begin : g_cs
      assign pad_cs[g] = active && (region_q == RG_W'(g));
   end
endmodule

// File: rtl/mbs_rdata_cap.sv
module mbs_rdata_cap
   import mbs_pkg::*;
#(
   parameter int DATA_W = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  phase_e            phase,
   input  logic              wr_q,
   input  logic [DATA_W-1:0] pad_ad_in,
   output logic [DATA_W-1:0] rdata
);
   logic [DATA_W-1:0] cap_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cap_q <= '0;
      end else if (phase == PH_T3 && !wr_q) begin
         cap_q <= pad_ad_in;
      end
   end

   assign rdata = (phase == PH_T4 && !wr_q) ? cap_q : '0;
endmodule

// File: rtl/mux_bus_seq.sv
module mux_bus_seq
   import mbs_pkg::*;
#(
   parameter int ADDR_W     = 20,
   parameter int DATA_W     = 16,
   parameter int NUM_CS     = 3,
   parameter int LOWER_CODE = 1,
   parameter int UPPER_CODE = 2,
   localparam int RG_W      = $clog2(NUM_CS + 1)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              force_mux_n,
   input  logic              cfg_we,
   input  logic [1:0]        cfg_wdata,
   input  logic              req_valid,
   output logic              req_ready,
   input  logic              req_write,
   input  logic [RG_W-1:0]   req_region,
   input  logic [ADDR_W-1:0] req_addr,
   input  logic [DATA_W-1:0] req_wdata,
   output logic              done,
   output logic [DATA_W-1:0] rdata,
   output logic [ADDR_W-1:0] pad_addr,
   output logic [DATA_W-1:0] pad_ad_out,
   output logic              pad_ad_oe,
   input  logic [DATA_W-1:0] pad_ad_in,
   output logic [NUM_CS-1:0] pad_cs
);
   if (ADDR_W < DATA_W) begin : g_bad_width
      $error("ADDR_W must be at least DATA_W");
   end
   if (LOWER_CODE >= NUM_CS || UPPER_CODE >= NUM_CS || LOWER_CODE == UPPER_CODE) begin : g_bad_codes
      $error("region codes must be distinct chip-select indices");
   end

   logic                armed;
   logic                strap_q;
   logic                strap_eff;
   logic [CFG_BITS-1:0] cfg_q;
   logic                dis_now;
   phase_e              phase;
   logic [ADDR_W-1:0]   addr_q;
   logic [DATA_W-1:0]   wdata_q;
   logic [RG_W-1:0]     region_q;
   logic                wr_q;
   logic                dis_q;

   mbs_strap_cfg #(.CFG_W(CFG_BITS)) u_cfg (
      .clk       (clk),
      .rst_n     (rst_n),
      .strap_i   (force_mux_n),
      .cfg_we    (cfg_we),
      .cfg_wdata (cfg_wdata),
      .armed     (armed),
      .strap_q   (strap_q),
      .strap_eff (strap_eff),
      .cfg_q     (cfg_q)
   );

   // address-phase disable decision for the request being presented
   assign dis_now = strap_eff &&
      ((req_region == RG_W'(LOWER_CODE) && cfg_q[CFG_LOWER_BIT]) ||
       (req_region == RG_W'(UPPER_CODE) && cfg_q[CFG_UPPER_BIT]));

   mbs_phase_fsm #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .RG_W(RG_W)) u_fsm (
      .clk        (clk),
      .rst_n      (rst_n),
      .req_valid  (req_valid),
      .req_write  (req_write),
      .req_region (req_region),
      .req_addr   (req_addr),
      .req_wdata  (req_wdata),
      .dis_now    (dis_now),
      .req_ready  (req_ready),
      .phase      (phase),
      .addr_q     (addr_q),
      .wdata_q    (wdata_q),
      .region_q   (region_q),
      .wr_q       (wr_q),
      .dis_q      (dis_q)
   );

   mbs_pad_drive #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .NUM_CS(NUM_CS), .RG_W(RG_W)) u_pad (
      .phase      (phase),
      .addr_q     (addr_q),
      .wdata_q    (wdata_q),
      .region_q   (region_q),
      .wr_q       (wr_q),
      .dis_q      (dis_q),
      .pad_addr   (pad_addr),
      .pad_ad_out (pad_ad_out),
      .pad_ad_oe  (pad_ad_oe),
      .pad_cs     (pad_cs),
      .done       (done)
   );

   mbs_rdata_cap #(.DATA_W(DATA_W)) u_rd (
      .clk       (clk),
      .rst_n     (rst_n),
      .phase     (phase),
      .wr_q      (wr_q),
      .pad_ad_in (pad_ad_in),
      .rdata     (rdata)
   );
endmodule

// File: rtl/mbs_chk.sv
module mbs_chk
   import mbs_pkg::*;
#(
   parameter int ADDR_W = 20,
   parameter int DATA_W = 16,
   parameter int NUM_CS = 3
) (
   input logic              clk,
   input logic              rst_n,
   input logic              req_ready,
   input logic              done,
   input logic [NUM_CS-1:0] pad_cs,
   input logic [ADDR_W-1:0] pad_addr,
   input logic [DATA_W-1:0] pad_ad_out,
   input logic              pad_ad_oe,
   input phase_e            phase,
   input logic              wr_q,
   input logic              strap_q,
   input logic              armed
);
   // R12
   cs_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(pad_cs));

   // R2
   done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);

   // R11
   ready_at_t4_chk: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> req_ready);

   // R3
   addr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (phase != PH_IDLE && !done) |=> $stable(pad_addr));

   // R4
   t1_addr_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (phase == PH_T1 && pad_ad_oe) |-> (pad_ad_out == pad_addr[DATA_W-1:0]));

   // R6
   read_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (phase inside {PH_T2, PH_T3, PH_T4} && !wr_q) |-> !pad_ad_oe);

   // R9
   strap_force_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!armed && !strap_q && phase == PH_T1) |-> pad_ad_oe);

   // R10
   strap_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !armed |=> $stable(strap_q));
endmodule

bind mux_bus_seq mbs_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .NUM_CS(NUM_CS)) u_chk (.*);

// File: tb/sim_mux_bus_seq.sv
`timescale 1ns/1ps
module sim_mux_bus_seq;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        force_mux_n = 1'b1;
   logic        cfg_we = 1'b0;
   logic [1:0]  cfg_wdata = '0;
   logic        req_valid = 1'b0;
   logic        req_ready;
   logic        req_write = 1'b0;
   logic [1:0]  req_region = '0;
   logic [19:0] req_addr = '0;
   logic [15:0] req_wdata = '0;
   logic        done;
   logic [15:0] rdata;
   logic [19:0] pad_addr;
   logic [15:0] pad_ad_out;
   logic        pad_ad_oe;
   logic [15:0] pad_ad_in = '0;
   logic [2:0]  pad_cs;

   int checks = 0;
   int errors = 0;
   logic [1:0] cfg_m = '0;
   logic       strap_m = 1'b1;

   always #2.5 clk = ~clk;

   mux_bus_seq u0 (.*);

   task automatic chk(input bit ok, input string req, input string what,
                      input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
      end
   endtask

   function automatic logic exp_dis(input logic [1:0] rg, input logic [1:0] cfg, input logic strap);
      return strap && ((rg == 2'd1 && cfg[0]) || (rg == 2'd2 && cfg[1]));
   endfunction

   function automatic logic [2:0] exp_cs(input logic [1:0] rg);
      return (rg == 2'd3) ? 3'b000 : (3'b001 << rg);
   endfunction

   task automatic step();
      @(posedge clk);
      #1;
   endtask

   task automatic do_reset(input logic strap);
      rst_n = 1'b0;
      req_valid = 1'b0;
      cfg_we = 1'b0;
      force_mux_n = strap;
      repeat (3) step();
      rst_n = 1'b1;
      step();
      strap_m = strap;
      cfg_m = '0;
   endtask

   task automatic write_cfg(input logic [1:0] v);
      cfg_we = 1'b1;
      cfg_wdata = v;
      step();
      cfg_we = 1'b0;
      cfg_m = v;
   endtask

   task automatic set_req(input logic w, input logic [19:0] a, input logic [15:0] d, input logic [1:0] rg);
      req_valid = 1'b1;
      req_write = w;
      req_addr = a;
      req_wdata = d;
      req_region = rg;
   endtask

   // entry: request driven, block idle or in t4; exit: sample point of t4
   task automatic xfer(input logic w, input logic [19:0] a, input logic [15:0] d,
                       input logic [1:0] rg, input logic [15:0] rdv);
      logic dis;
      dis = exp_dis(rg, cfg_m, strap_m);
      chk(req_ready == 1'b1, "R11", "ready before accept", req_ready, 1);
      step();
      req_valid = 1'b0;
      // t1
      chk(pad_cs == exp_cs(rg), "R12", "cs in t1", pad_cs, exp_cs(rg));
      chk(pad_addr == a, "R3", "addr in t1", pad_addr, a);
      chk(req_ready == 1'b0, "R11", "ready in t1", req_ready, 0);
      chk(done == 1'b0, "R2", "done in t1", done, 0);
      if (dis) begin
         chk(pad_ad_oe == 1'b0, "R7", "oe in disabled t1", pad_ad_oe, 0);
      end else begin
         chk(pad_ad_oe == 1'b1, (rg == 0 || rg == 3) ? "R8" : (strap_m ? "R4" : "R9"),
             "oe in t1", pad_ad_oe, 1);
         chk(pad_ad_out == a[15:0], "R4", "ad in t1", pad_ad_out, a[15:0]);
      end
      // t2, t3, t4
      for (int p = 2; p <= 4; p++) begin
         step();
         if (p == 3) pad_ad_in = rdv;
         chk(pad_addr == a, "R3", "addr hold", pad_addr, a);
         chk(pad_cs == exp_cs(rg), "R12", "cs hold", pad_cs, exp_cs(rg));
         chk(pad_ad_oe == w, w ? "R5" : "R6", "oe in data phase", pad_ad_oe, w);
         if (w) chk(pad_ad_out == d, "R5", "write data", pad_ad_out, d);
         chk(done == (p == 4), "R2", "done timing", done, p == 4);
         chk(req_ready == (p == 4), "R11", "ready in data phase", req_ready, p == 4);
      end
      if (!w) chk(rdata == rdv, "R6", "read data", rdata, rdv);
      pad_ad_in = $urandom();
   endtask

   task automatic idle_after();
      step();
      chk(done == 1'b0, "R2", "done after t4", done, 0);
      chk(pad_cs == 3'b000, "R2", "idle cs", pad_cs, 0);
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      errors++;
      $display("FAIL R2 watchdog actual=hung expected=finished");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      void'($urandom(32'h5eed_0042));
      do_reset(1'b1);
      // R1 reset state
      chk(req_ready == 1'b1, "R1", "ready", req_ready, 1);
      chk(done == 1'b0, "R1", "done", done, 0);
      chk(pad_cs == 3'b000, "R1", "cs", pad_cs, 0);
      chk(pad_ad_oe == 1'b0, "R1", "oe", pad_ad_oe, 0);
      // R1: default config multiplexes the upper region
      set_req(1'b0, 20'hABCDE, 16'h0, 2'd2);
      xfer(1'b0, 20'hABCDE, 16'h0, 2'd2, 16'h1357);
      idle_after();

      // R7 per-region disable, R8 other regions ignore it
      write_cfg(2'b11);
      set_req(1'b1, 20'h12345, 16'hBEEF, 2'd1);
      xfer(1'b1, 20'h12345, 16'hBEEF, 2'd1, 16'h0);
      idle_after();
      set_req(1'b0, 20'hF0F0F, 16'h0, 2'd2);
      xfer(1'b0, 20'hF0F0F, 16'h0, 2'd2, 16'hCAFE);
      idle_after();
      set_req(1'b1, 20'h00FFF, 16'h5A5A, 2'd0);
      xfer(1'b1, 20'h00FFF, 16'h5A5A, 2'd0, 16'h0);
      idle_after();
      set_req(1'b0, 20'h80001, 16'h0, 2'd3);
      xfer(1'b0, 20'h80001, 16'h0, 2'd3, 16'h0F0F);
      idle_after();
      write_cfg(2'b01);
      set_req(1'b0, 20'h7FFFF, 16'h0, 2'd2);
      xfer(1'b0, 20'h7FFFF, 16'h0, 2'd2, 16'hFFFF);

      // R11 back-to-back from t4
      set_req(1'b1, 20'h00001, 16'h0001, 2'd1);
      xfer(1'b1, 20'h00001, 16'h0001, 2'd1, 16'h0);
      idle_after();

      // R9 strap low at reset forces multiplexing; R10 later change ignored
      do_reset(1'b0);
      force_mux_n = 1'b1;
      write_cfg(2'b11);
      set_req(1'b0, 20'h22222, 16'h0, 2'd1);
      xfer(1'b0, 20'h22222, 16'h0, 2'd1, 16'h4444);
      idle_after();
      set_req(1'b1, 20'h33333, 16'h9999, 2'd2);
      xfer(1'b1, 20'h33333, 16'h9999, 2'd2, 16'h0);
      idle_after();

      // R10: strap high at reset, pulled low afterwards, disable still applies
      do_reset(1'b1);
      force_mux_n = 1'b0;
      write_cfg(2'b10);
      set_req(1'b1, 20'h44444, 16'h1111, 2'd2);
      xfer(1'b1, 20'h44444, 16'h1111, 2'd2, 16'h0);
      idle_after();

      // random traffic
      for (int i = 0; i < 120; i++) begin
         logic        w;
         logic [19:0] a;
         logic [15:0] d;
         logic [15:0] rv;
         logic [1:0]  rg;
         bit          chain;
         if (($urandom() % 6) == 0) write_cfg(2'($urandom()));
         w  = 1'($urandom());
         a  = 20'($urandom());
         d  = 16'($urandom());
         rv = 16'($urandom());
         rg = 2'($urandom());
         set_req(w, a, d, rg);
         xfer(w, a, d, rg, rv);
         chain = 1'($urandom());
         while (chain) begin
            w  = 1'($urandom());
            a  = 20'($urandom());
            d  = 16'($urandom());
            rv = 16'($urandom());
            rg = 2'($urandom());
            set_req(w, a, d, rg);
            xfer(w, a, d, rg, rv);
            chain = (($urandom() % 3) == 0);
         end
         idle_after();
      end

      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule